// File: doc/BRIEF.md
# Index Register Loop Unit

This block holds the index registers of a single-address machine and does the address and loop-control work that depends on them. Each decoded instruction supplies an operation code, an index designator and an address field, together with the current program counter. The unit returns the effective operand address, the program counter of the following instruction and a flag that marks a taken branch. Operand memory access and operand arithmetic are handled elsewhere.

Two instructions act on the index registers. The first, load-index, writes the address field into the selected register. The second, count-and-branch, drives counted loops. While the selected register is nonzero, it lowers the register by one and jumps to the address field in a single step. When the register is already zero, it leaves the register unchanged and execution carries on in sequence. Designator zero means that no index register takes part.

Top module: `idx_loop_unit`

## Requirements
- R1: When `idx_sel` is 0, `eff_addr` equals `addr_fld` for every operation.
- R2: When `idx_sel` is 1, 2 or 3, `eff_addr` equals `addr_fld` plus the selected index register, taken modulo 4096. This uses the register value held before any update in the same cycle.
- R3: Load-index (`op_code` 2'b01) with a nonzero designator writes `addr_fld` into the selected register. The new value is visible to the next instruction, and the other registers keep their values.
- R4: Count-and-branch (`op_code` 2'b10) on a nonzero register does three things: it sets `br_taken` to 1, it sets `pc_next` to `addr_fld`, and it lowers that register by exactly 1 for the next instruction.
- R5: Count-and-branch on a register holding zero gives `br_taken` = 0 and `pc_next` = `pc_cur` + 1, and the register stays at zero.
- R6: Any other operation (`op_code` 2'b00 or 2'b11) gives `br_taken` = 0 and `pc_next` = `pc_cur` + 1, and changes no index register.
- R7: Synchronous active-high `rst` clears all three index registers to zero.
- R8: Load-index or count-and-branch with designator 0 changes no register and never branches.
- R9: The sequential `pc_next` wraps from 4095 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 2 | 00 memory reference, 01 load-index, 10 count-and-branch, 11 memory reference |
| idx_sel | input | 2 | Index designator; 0 means none |
| addr_fld | input | 12 | Instruction address field |
| pc_cur | input | 12 | Program counter of the current instruction |
| eff_addr | output | 12 | Effective operand address |
| pc_next | output | 12 | Program counter of the next instruction |
| br_taken | output | 1 | High when count-and-branch jumps |

## Verification
The bench counts an index register down through a complete loop and ends on two fall-through passes. A design that decrements past zero, or that still jumps on zero, would wrap the register to 4095 and loop again. Sums that overflow 4096 catch an adder that saturates or widens its result. Designator 0 is driven with both register-writing operations to expose a design that writes a hidden register 0. Each register's value is read back through the effective address after writes to its neighbours, which shows any write that lands in the wrong register. A program counter of 4095 catches sequencing that does not wrap.

// File: rtl/idx_pkg.sv
package idx_pkg;
    parameter int unsigned ADDR_W  = 12;
    parameter int unsigned NUM_IDX = 3;
    localparam int unsigned SEL_W  = $clog2(NUM_IDX + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [SEL_W-1:0]  sel_t;

    typedef enum logic [1:0] {
        OP_MREF  = 2'b00,
        OP_LDIX  = 2'b01,
        OP_CNTBR = 2'b10,
        OP_MREF2 = 2'b11
    } op_e;

    typedef struct packed {
        op_e   op;
        sel_t  sel;
        addr_t addr;
        addr_t pc;
    } ix_req_t;

    typedef struct packed {
        addr_t ea;
        addr_t pc_nxt;
        logic  taken;
    } ix_rsp_t;

    typedef struct packed {
        logic  en;
        sel_t  sel;
        addr_t data;
    } ix_wr_t;

    function automatic addr_t addr_wrap_add(addr_t a, addr_t b);
        return a + b;
    endfunction
endpackage

// File: rtl/idx_regfile.sv
module idx_regfile
    import idx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  sel_t   rd_sel,
    input  ix_wr_t wr,
    output addr_t  rd_val
);
    addr_t regs [NUM_IDX+1];

    assign regs[0] = '0;

    for (genvar gi = 1; gi <= NUM_IDX; gi++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[gi] <= '0;
            end else if (wr.en && wr.sel == sel_t'(gi)) begin
                regs[gi] <= wr.data;
            end
        end
    end

    always_comb begin
        rd_val = '0;
        for (int k = 1; k <= NUM_IDX; k++) begin
            if (rd_sel == sel_t'(k)) rd_val = regs[k];
        end
    end
endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen
    import idx_pkg::*;
(
    input  sel_t  sel,
    input  addr_t base,
    input  addr_t idx_val,
    output addr_t ea
);
    addr_t offset;

    always_comb begin
        offset = (sel == '0) ? '0 : idx_val;
        ea     = addr_wrap_add(base, offset);
    end
endmodule

// File: rtl/idx_seq.sv
module idx_seq
    import idx_pkg::*;
(
    input  ix_req_t req,
    input  addr_t   idx_val,
    output addr_t   pc_nxt,
    output logic    taken,
    output ix_wr_t  wr
);
    logic has_idx;
    logic nonzero;

    always_comb begin
        has_idx = (req.sel != '0);
        nonzero = has_idx && (idx_val != '0);
        taken   = 1'b0;
        pc_nxt  = addr_wrap_add(req.pc, addr_t'(1));
        wr.en   = 1'b0;
        wr.sel  = req.sel;
        wr.data = req.addr;
        unique case (req.op)
            OP_LDIX: begin
                wr.en = has_idx;
            end
            OP_CNTBR: begin
                if (nonzero) begin
                    taken   = 1'b1;
                    pc_nxt  = req.addr;
                    wr.en   = 1'b1;
                    wr.data = idx_val - addr_t'(1);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/idx_loop_unit.sv
module idx_loop_unit
    import idx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        op_code,
    input  logic [SEL_W-1:0]  idx_sel,
    input  logic [ADDR_W-1:0] addr_fld,
    input  logic [ADDR_W-1:0] pc_cur,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] pc_next,
    output logic              br_taken
);
    ix_req_t req;
    ix_rsp_t rsp;
    ix_wr_t  wr;
    addr_t   sel_val;

    assign req.op   = op_e'(op_code);
    assign req.sel  = idx_sel;
    assign req.addr = addr_fld;
    assign req.pc   = pc_cur;

    idx_regfile u_rf (
        .clk    (clk),
        .rst    (rst),
        .rd_sel (req.sel),
        .wr     (wr),
        .rd_val (sel_val)
    );

    idx_addr_gen u_ag (
        .sel     (req.sel),
        .base    (req.addr),
        .idx_val (sel_val),
        .ea      (rsp.ea)
    );

    idx_seq u_seq (
        .req     (req),
        .idx_val (sel_val),
        .pc_nxt  (rsp.pc_nxt),
        .taken   (rsp.taken),
        .wr      (wr)
    );

    assign eff_addr = rsp.ea;
    assign pc_next  = rsp.pc_nxt;
    assign br_taken = rsp.taken;
endmodule

// File: rtl/idx_loop_unit_chk.sv
module idx_loop_unit_chk
    import idx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [1:0]        op_code,
    input logic [SEL_W-1:0]  idx_sel,
    input logic [ADDR_W-1:0] addr_fld,
    input logic [ADDR_W-1:0] pc_cur,
    input logic [ADDR_W-1:0] eff_addr,
    input logic [ADDR_W-1:0] pc_next,
    input logic              br_taken,
    input logic [ADDR_W-1:0] sel_val
);
    logic seen_clk;
    always_ff @(posedge clk) seen_clk <= 1'b1;

    a_r1_no_index_passthru: assert property (@(posedge clk) disable iff (rst)
        (idx_sel == '0) |-> (eff_addr == addr_fld));

    a_r3_load_visible: assert property (@(posedge clk) disable iff (rst)
        (op_code == 2'b01 && idx_sel != '0) |=>
            (idx_sel != $past(idx_sel) || sel_val == $past(addr_fld)));

    a_r4_taken_target: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> (op_code == 2'b10 && pc_next == addr_fld && idx_sel != '0));

    a_r4_decrement: assert property (@(posedge clk) disable iff (rst)
        (op_code == 2'b10 && idx_sel != '0 && eff_addr != addr_fld) |=>
            (idx_sel != $past(idx_sel) || sel_val == ADDR_W'($past(sel_val) - 1'b1)));

    a_r5_zero_falls_through: assert property (@(posedge clk) disable iff (rst)
        (op_code == 2'b10 && eff_addr == addr_fld) |->
            (!br_taken && pc_next == ADDR_W'(pc_cur + 1'b1)));

    a_r6_mref_holds: assert property (@(posedge clk) disable iff (rst)
        (op_code[1] == op_code[0]) |=>
            (idx_sel != $past(idx_sel) || $stable(sel_val)));

    a_r7_reset_clears: assert property (@(posedge clk)
        (seen_clk && $past(rst)) |-> (sel_val == '0));
endmodule

bind idx_loop_unit idx_loop_unit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_code  (op_code),
    .idx_sel  (idx_sel),
    .addr_fld (addr_fld),
    .pc_cur   (pc_cur),
    .eff_addr (eff_addr),
    .pc_next  (pc_next),
    .br_taken (br_taken),
    .sel_val  (sel_val)
);

// File: tb/idx_loop_unit_tb.sv
`timescale 1ns/1ps
module idx_loop_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  op_code = 2'b00;
    logic [1:0]  idx_sel = 2'b00;
    logic [11:0] addr_fld = '0;
    logic [11:0] pc_cur = '0;
    logic [11:0] eff_addr, pc_next;
    logic        br_taken;

    always #2 clk = ~clk;

    idx_loop_unit u_dut (
        .clk(clk), .rst(rst), .op_code(op_code), .idx_sel(idx_sel),
        .addr_fld(addr_fld), .pc_cur(pc_cur),
        .eff_addr(eff_addr), .pc_next(pc_next), .br_taken(br_taken)
    );

    typedef struct {
        logic [11:0] ea;
        logic [11:0] pcn;
        logic        tk;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [11:0] mdl [4];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    task automatic apply(input logic [1:0] op, input logic [1:0] sel,
                         input logic [11:0] a, input logic [11:0] pc,
                         input string tag);
        exp_t e;
        logic [11:0] v;
        @(negedge clk);
        op_code = op; idx_sel = sel; addr_fld = a; pc_cur = pc;
        v = (sel == 2'd0) ? 12'd0 : mdl[sel];
        e.ea  = a + v;
        e.tk  = (op == 2'b10) && (v != 12'd0);
        e.pcn = e.tk ? a : pc + 12'd1;
        e.tag = tag;
        sb.push_back(e);
        if (sel != 2'd0) begin
            if (op == 2'b01) mdl[sel] = a;
            else if (e.tk)   mdl[sel] = v - 12'd1;
        end
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() != 0) begin
                e = sb.pop_front();
                n_chk++;
                if (eff_addr !== e.ea || pc_next !== e.pcn || br_taken !== e.tk) begin
                    n_bad++;
                    $display("FAIL %s: got ea=%h pcn=%h tk=%b, expected ea=%h pcn=%h tk=%b",
                             e.tag, eff_addr, pc_next, br_taken, e.ea, e.pcn, e.tk);
                end
            end
        end
    end

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : driver
        for (int i = 0; i < 4; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R7: all registers zero after reset
        for (int s = 1; s < 4; s++) apply(2'b00, 2'(s), 12'h005, 12'h010, "R7 reset clear");
        // R1: no index
        apply(2'b00, 2'd0, 12'h123, 12'h00A, "R1 designator zero");
        // R3 then R2
        apply(2'b01, 2'd1, 12'd300, 12'h020, "R3 load reg1");
        apply(2'b00, 2'd1, 12'd200, 12'h021, "R2 300+200");
        apply(2'b01, 2'd2, 12'hFFF, 12'h022, "R3 load reg2");
        apply(2'b00, 2'd2, 12'h002, 12'h023, "R2 wrap sum");
        apply(2'b01, 2'd3, 12'd7,   12'h024, "R3 load reg3");
        apply(2'b00, 2'd1, 12'h000, 12'h025, "R3 reg1 untouched");
        apply(2'b00, 2'd2, 12'h000, 12'h026, "R3 reg2 untouched");
        // R4 then R5: count reg3 down through a full loop
        for (int k = 0; k < 9; k++) apply(2'b10, 2'd3, 12'h040, 12'h030, "R4/R5 count loop");
        apply(2'b00, 2'd3, 12'h011, 12'h031, "R5 reg3 stays zero");
        apply(2'b10, 2'd1, 12'h050, 12'h032, "R4 taken reg1");
        apply(2'b00, 2'd1, 12'h000, 12'h033, "R4 reg1 decremented");
        // R8: designator zero on writing ops
        apply(2'b01, 2'd0, 12'd55,  12'h040, "R8 load sel0");
        apply(2'b10, 2'd0, 12'h070, 12'h041, "R8 branch sel0");
        apply(2'b00, 2'd0, 12'h0AA, 12'h042, "R8 sel0 still none");
        // R6: op 11 and 00 change nothing
        apply(2'b11, 2'd2, 12'h100, 12'h050, "R6 op11");
        apply(2'b00, 2'd2, 12'h000, 12'h051, "R6 reg2 held");
        // R9: pc wrap
        apply(2'b00, 2'd0, 12'h000, 12'hFFF, "R9 pc wrap");
        apply(2'b10, 2'd3, 12'h000, 12'hFFF, "R9 fall-through wrap");
        // R7: reset again clears loaded registers
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        for (int i = 0; i < 4; i++) mdl[i] = '0;
        apply(2'b10, 2'd1, 12'h060, 12'h070, "R7 reg1 cleared");
        apply(2'b00, 2'd2, 12'h001, 12'h071, "R7 reg2 cleared");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule